// File: doc/BRIEF.md
# Lockable SMRAM Window Control Register

This block is a single byte-wide configuration register in a host-bridge configuration space. Firmware uses it in two steps. First it probes whether a low-memory system-management RAM window is available. Then it seals that window so that only code running in system-management mode can reach it. The register answers configuration byte reads and writes at one fixed offset. Alongside the register sits a memory-access checker. The checker takes an access address and the CPU's system-management-mode flag, and returns allow or deny.

The probe works like this: firmware writes the query code, then reads the register back. The read returns a capability code that says whether the window feature exists. Until the window is locked it stays open, so ordinary code may use it. A write of the lock code closes the 128 KB window at 0x30000 to non-SMM accesses. The lock also freezes the register against all later writes. Only a platform reset reopens the window and restores write access. A build parameter removes the feature entirely. The probe then reports absence, and the lock code does nothing.

Top module: `smram_lock_ctl`

## Requirements
- R1: After reset the register reads 0x00, the window is unlocked, and every access is allowed.
- R2: A write of 0xFF (query) to offset 0x9C makes later reads of that offset return 0x01 when the feature is present.
- R3: While unlocked, accesses inside the window from non-SMM code are allowed.
- R4: A write of 0x02 (lock) to offset 0x9C, with the feature present, locks the window, whether or not a query came first. From then on the register reads 0x02.
- R5: While locked, an access with the SMM flag low to any address from 0x30000 to 0x4FFFF inclusive is denied.
- R6: While locked, every write to the register is ignored: the readback stays 0x02 and the window stays denied.
- R7: An access with the SMM flag high is always allowed.
- R8: Addresses below 0x30000 or at or above 0x50000 are always allowed.
- R9: While unlocked, a write of any value other than 0xFF or 0x02 leaves the state and the readback unchanged.
- R10: Writes to any other offset have no effect on the register, and reads of any other offset return 0x00.
- R11: Reset clears the lock, reopens the window and makes the register writable again.
- R12: With the feature parameter cleared, a read after a query returns 0x00, the lock code has no effect, and the window is never denied.
- R13: A write takes effect at the clock edge that samples it. Read data is registered: it reflects the state at the sampling edge and appears one cycle after the offset is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous platform reset |
| cfg_addr_i | input | 8 | Configuration byte offset, used for both reads and writes |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_rdata_o | output | 8 | Registered configuration read data |
| acc_addr_i | input | 32 | Memory access address to check |
| acc_smm_i | input | 1 | High when the CPU is in system-management mode |
| acc_allow_o | output | 1 | High when the access is permitted |

## Verification
On every cycle the assertions check these properties:
- The lock is sticky.
- A deny only ever comes from a locked window, an in-range address and the SMM flag low.
- SMM accesses and out-of-range addresses are always allowed.
- A locked register at the decoded offset reads back the lock code.
- Other offsets read zero.

Several behaviours can only be shown by the bench's scenarios, because they depend on sequences:
- The query-then-read capability code, and that a query is not needed before locking.
- That stray values and stray offsets are ignored before lock.
- That the old value is returned in the write cycle.
- That reset reopens the window.
- That the feature-absent build stays inert.

// File: rtl/smram_ctl_pkg.sv
package smram_ctl_pkg;
  localparam int unsigned BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CODE_QUERY  = 8'hFF;
  localparam logic [BYTE_W-1:0] CODE_LOCK   = 8'h02;
  localparam logic [BYTE_W-1:0] CODE_AVAIL  = 8'h01;
  localparam logic [BYTE_W-1:0] CODE_IDLE   = 8'h00;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_QUERIED = 2'd1,
    ST_LOCKED  = 2'd2
  } lock_state_e;

  typedef struct packed {
    logic hit;
    logic query;
    logic lock;
  } cfg_wr_t;
endpackage

// File: rtl/smram_cfg_decode.sv
module smram_cfg_decode
  import smram_ctl_pkg::*;
#(
  parameter logic [BYTE_W-1:0] CFG_OFFSET = 8'h9C
) (
  input  logic [BYTE_W-1:0] cfg_addr_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic              rd_hit_o,
  output cfg_wr_t           wr_o
);
  always_comb begin
    rd_hit_o   = (cfg_addr_i == CFG_OFFSET);
    wr_o.hit   = cfg_we_i && rd_hit_o;
    wr_o.query = wr_o.hit && (cfg_wdata_i == CODE_QUERY);
    wr_o.lock  = wr_o.hit && (cfg_wdata_i == CODE_LOCK);
  end
endmodule

// File: rtl/smram_lock_fsm.sv
module smram_lock_fsm
  import smram_ctl_pkg::*;
#(
  parameter bit FEATURE_PRESENT = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  cfg_wr_t     wr_i,
  output lock_state_e state_o,
  output logic        locked_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_QUERIED: begin
        // lock needs the feature; any other value leaves state alone
        if (wr_i.lock && FEATURE_PRESENT) state_d = ST_LOCKED;
        else if (wr_i.query)              state_d = ST_QUERIED;
      end
      ST_LOCKED: state_d = ST_LOCKED;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o  = state_q;
  assign locked_o = (state_q == ST_LOCKED);
endmodule

// File: rtl/smram_window_dec.sv
module smram_window_dec #(
  parameter int unsigned       ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE = 32'h0002_0000
) (
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_smm_i,
  input  logic              locked_i,
  output logic              in_win_o,
  output logic              allow_o
);
  localparam logic [ADDR_W:0] WIN_END = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE};

  always_comb begin
    in_win_o = ({1'b0, acc_addr_i} >= {1'b0, WIN_BASE}) &&
               ({1'b0, acc_addr_i} <  WIN_END);
    allow_o  = !(in_win_o && locked_i && !acc_smm_i);
  end
endmodule

// File: rtl/smram_rdata.sv
module smram_rdata
  import smram_ctl_pkg::*;
#(
  parameter bit FEATURE_PRESENT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_hit_i,
  input  lock_state_e       state_i,
  output logic [BYTE_W-1:0] rdata_o
);
  logic [BYTE_W-1:0] val;

  always_comb begin
    unique case (state_i)
      ST_QUERIED: val = FEATURE_PRESENT ? CODE_AVAIL : CODE_IDLE;
      ST_LOCKED:  val = CODE_LOCK;
      default:    val = CODE_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_o <= '0;
    else         rdata_o <= rd_hit_i ? val : '0;
  end
endmodule

// File: rtl/smram_lock_ctl.sv
module smram_lock_ctl
  import smram_ctl_pkg::*;
#(
  parameter bit                FEATURE_PRESENT = 1'b1,
  parameter logic [7:0]        CFG_OFFSET      = 8'h9C,
  parameter int unsigned       ADDR_W          = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE        = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE        = 32'h0002_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        cfg_addr_i,
  input  logic [7:0]        cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [7:0]        cfg_rdata_o,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              acc_smm_i,
  output logic              acc_allow_o
);
  logic        rd_hit;
  cfg_wr_t     wr;
  lock_state_e state;
  logic        lock_q;
  logic        in_win;

  smram_cfg_decode #(.CFG_OFFSET(CFG_OFFSET)) u_dec (
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .cfg_we_i   (cfg_we_i),
    .rd_hit_o   (rd_hit),
    .wr_o       (wr)
  );

  smram_lock_fsm #(.FEATURE_PRESENT(FEATURE_PRESENT)) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr),
    .state_o (state),
    .locked_o(lock_q)
  );

  smram_window_dec #(
    .ADDR_W  (ADDR_W),
    .WIN_BASE(WIN_BASE),
    .WIN_SIZE(WIN_SIZE)
  ) u_win (
    .acc_addr_i(acc_addr_i),
    .acc_smm_i (acc_smm_i),
    .locked_i  (lock_q),
    .in_win_o  (in_win),
    .allow_o   (acc_allow_o)
  );

  smram_rdata #(.FEATURE_PRESENT(FEATURE_PRESENT)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_hit_i(rd_hit),
    .state_i (state),
    .rdata_o (cfg_rdata_o)
  );
endmodule

// File: rtl/smram_lock_ctl_chk.sv
module smram_lock_ctl_chk #(
  parameter bit                FEATURE_PRESENT = 1'b1,
  parameter logic [7:0]        CFG_OFFSET      = 8'h9C,
  parameter int unsigned       ADDR_W          = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE        = 32'h0003_0000,
  parameter logic [ADDR_W-1:0] WIN_SIZE        = 32'h0002_0000
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [7:0]        cfg_addr_i,
  input logic [7:0]        cfg_rdata_o,
  input logic [ADDR_W-1:0] acc_addr_i,
  input logic              acc_smm_i,
  input logic              acc_allow_o,
  input logic              lock_q
);
  localparam logic [ADDR_W:0] LAST = {1'b0, WIN_BASE} + {1'b0, WIN_SIZE} - 1;

  logic in_range;
  assign in_range = ({1'b0, acc_addr_i} >= {1'b0, WIN_BASE}) && ({1'b0, acc_addr_i} <= LAST);

  assert_open_allow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_q |-> acc_allow_o);
  assert_locked_readback_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lock_q) && $past(cfg_addr_i) == CFG_OFFSET) |-> cfg_rdata_o == 8'h02);
  assert_deny_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_allow_o |-> (lock_q && !acc_smm_i && in_range));
  assert_lock_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q);
  assert_smm_allow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_smm_i |-> acc_allow_o);
  assert_outside_allow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_range |-> acc_allow_o);
  assert_other_offset_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(cfg_addr_i) != CFG_OFFSET) |-> cfg_rdata_o == 8'h00);
  assert_absent_never_locks_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !FEATURE_PRESENT |-> !lock_q);
endmodule

bind smram_lock_ctl smram_lock_ctl_chk #(
  .FEATURE_PRESENT(FEATURE_PRESENT),
  .CFG_OFFSET     (CFG_OFFSET),
  .ADDR_W         (ADDR_W),
  .WIN_BASE       (WIN_BASE),
  .WIN_SIZE       (WIN_SIZE)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cfg_addr_i (cfg_addr_i),
  .cfg_rdata_o(cfg_rdata_o),
  .acc_addr_i (acc_addr_i),
  .acc_smm_i  (acc_smm_i),
  .acc_allow_o(acc_allow_o),
  .lock_q     (lock_q)
);

// File: tb/tb_smram_lock_ctl.sv
`timescale 1ns/1ps
module tb_smram_lock_ctl;
  localparam logic [7:0] OFF = 8'h9C;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] exp_nf;
    int         due;
    string      tag;
  } rd_item_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        acc_smm = 1'b0;
  logic [7:0]  rdata, rdata_nf;
  logic        allow, allow_nf;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 1'b0;
  rd_item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  smram_lock_ctl dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_we_i(cfg_we), .cfg_rdata_o(rdata), .acc_addr_i(acc_addr),
    .acc_smm_i(acc_smm), .acc_allow_o(allow)
  );

  smram_lock_ctl #(.FEATURE_PRESENT(1'b0)) dut_nf (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_we_i(cfg_we), .cfg_rdata_o(rdata_nf), .acc_addr_i(acc_addr),
    .acc_smm_i(acc_smm), .acc_allow_o(allow_nf)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // monitor: compare registered read data one cycle after the offset was presented
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due <= cyc) begin
      rd_item_t it;
      it = q.pop_front();
      check(rdata == it.exp, {it.tag, " rdata"}, rdata, it.exp);
      check(rdata_nf == it.exp_nf, {it.tag, " rdata absent-build"}, rdata_nf, it.exp_nf);
    end
  end

  task automatic cfg_rd(input logic [7:0] a, input logic [7:0] e, input logic [7:0] enf,
                        input string tag);
    cfg_addr = a;
    cfg_we   = 1'b0;
    q.push_back('{exp: e, exp_nf: enf, due: cyc + 1, tag: tag});
    @(negedge clk);
  endtask

  // write; the read of the same offset in the same cycle returns the old value
  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d, input logic [7:0] old_e,
                        input logic [7:0] old_enf, input string tag);
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_we    = 1'b1;
    q.push_back('{exp: (a == OFF) ? old_e : 8'h00, exp_nf: (a == OFF) ? old_enf : 8'h00,
                  due: cyc + 1, tag: tag});
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic acc(input logic [31:0] a, input logic smm, input logic e, input logic enf,
                     input string tag);
    acc_addr = a;
    acc_smm  = smm;
    #1;
    check(allow == e, {tag, " allow"}, allow, e);
    check(allow_nf == enf, {tag, " allow absent-build"}, allow_nf, enf);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    @(negedge clk);
    do_reset();
    check(rdata == 8'h00, "R1 reset rdata", rdata, 0);
    cfg_rd(OFF, 8'h00, 8'h00, "R1");
    acc(32'h0003_0000, 1'b0, 1'b1, 1'b1, "R1");
    // R13: same-cycle read shows old value, next read shows new one
    cfg_wr(OFF, 8'hFF, 8'h00, 8'h00, "R13 query cycle");
    cfg_rd(OFF, 8'h01, 8'h00, "R2 R12 query readback");
    acc(32'h0004_0000, 1'b0, 1'b1, 1'b1, "R3 open window");
    cfg_wr(OFF, 8'h55, 8'h01, 8'h00, "R9 stray value");
    cfg_rd(OFF, 8'h01, 8'h00, "R9");
    cfg_wr(OFF, 8'h00, 8'h01, 8'h00, "R9 zero value");
    cfg_rd(OFF, 8'h01, 8'h00, "R9");
    acc(32'h0003_0000, 1'b0, 1'b1, 1'b1, "R9 still open");
    cfg_wr(8'h9D, 8'h02, 8'h00, 8'h00, "R10 other offset");
    cfg_rd(OFF, 8'h01, 8'h00, "R10");
    cfg_rd(8'h9D, 8'h00, 8'h00, "R10 other read");
    acc(32'h0003_0000, 1'b0, 1'b1, 1'b1, "R10 still open");
    cfg_wr(OFF, 8'h02, 8'h01, 8'h00, "R13 lock cycle");
    cfg_rd(OFF, 8'h02, 8'h00, "R4 R12 lock readback");
    acc(32'h0002_FFFF, 1'b0, 1'b1, 1'b1, "R8 below");
    acc(32'h0003_0000, 1'b0, 1'b0, 1'b1, "R5 R12 first");
    acc(32'h0004_0000, 1'b0, 1'b0, 1'b1, "R5 mid");
    acc(32'h0004_FFFF, 1'b0, 1'b0, 1'b1, "R5 last");
    acc(32'h0005_0000, 1'b0, 1'b1, 1'b1, "R8 above");
    acc(32'h0003_0000, 1'b1, 1'b1, 1'b1, "R7 smm");
    acc(32'h0004_FFFF, 1'b1, 1'b1, 1'b1, "R7 smm last");
    cfg_wr(OFF, 8'hFF, 8'h02, 8'h00, "R6 query ignored");
    cfg_rd(OFF, 8'h02, 8'h00, "R6");
    cfg_wr(OFF, 8'h00, 8'h02, 8'h00, "R6 clear ignored");
    cfg_rd(OFF, 8'h02, 8'h00, "R6");
    acc(32'h0003_8000, 1'b0, 1'b0, 1'b1, "R6 still denied");
    do_reset();
    cfg_rd(OFF, 8'h00, 8'h00, "R11 reset reopens");
    acc(32'h0003_8000, 1'b0, 1'b1, 1'b1, "R11");
    cfg_wr(OFF, 8'h02, 8'h00, 8'h00, "R4 lock without query");
    cfg_rd(OFF, 8'h02, 8'h00, "R4 R12");
    acc(32'h0003_8000, 1'b0, 1'b0, 1'b1, "R4 R12 direct lock");
    cfg_rd(8'h00, 8'h00, 8'h00, "R10 offset zero");
    repeat (3) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", q.size(), 0);
    report();
  end
endmodule